// File: doc/BRIEF.md
# Request-Gated Glitch-Free Clock Stopper

This block sits between a set of free-running lane clocks and the output drivers of a clock generator. It stops and restarts each lane cleanly in response to four active-low control pins: two request lines (A and B), a stop line for the processor lanes and a stop line for the bus lanes. A software run bit acts alongside the bus stop line. Per-lane configuration inputs choose which pins can halt each lane, the level the true output parks at, and whether a halted lane keeps driving or releases its outputs.

All logic runs on one system clock `clk`. The lane clocks and the reference clock are digital waveforms that are synchronous to `clk` and are at least two `clk` cycles per half-period. The four pins are asynchronous. Each passes through a two-flop synchroniser and is then accepted only when two successive falling edges of the reference clock (the rising edges of its complement) see the same value. A lane changes between running and stopped only in a cycle where its registered clock already equals its park level, so the true output never shows a shortened or stretched pulse.

Top module: `cs_clock_stopper`

## Requirements
- R1: A pin change takes effect only when the synchronised pin shows the same value at two successive falling edges of `ref_clk_i`; a pulse shorter than one reference period never stops or starts a lane, and no lane reacts sooner than four `clk` cycles after a pin change.
- R2: While a lane is stopped, its true output holds its park level (`park_hi_i` bit: 1 = high, 0 = low) and its complement output is 0; a lane mapped to a request line (`sel_a_i`, `sel_b_i`) stops when that line is accepted high.
- R3: A stopped lane resumes when no mapped stop condition is active, and a lane switches between running and stopped only in a cycle where its registered clock equals its park level.
- R4: A lane with its `cpu_ctl_i` bit set stops while `cpu_stop_n_i` is accepted low and resumes when it is accepted high.
- R5: A lane with its `pci_ctl_i` bit set stops while `pci_stop_n_i` is accepted low or `sw_run_i` is 0; lanes with the bit clear keep running through both.
- R6: `oe_o` of a lane is 1 while it runs; while stopped it is the inverse of its `hiz_i` bit (1 = release the outputs).
- R7: The true output of a running or parked lane changes only in a cycle where the lane clock changes, one `clk` cycle after the lane input.
- R8: Under reset, every lane is running with true output 0, complement output 1 and `oe_o` 1, and every pin is taken as asserted (low).
- R9: A lane ignores every control pin whose selection bit it does not have set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples everything |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock whose falling edges qualify pin changes |
| lane_clk_i | input | NUM_LANES | Free-running lane clocks |
| req_a_n_i | input | 1 | Request line A, high halts selected lanes |
| req_b_n_i | input | 1 | Request line B, high halts selected lanes |
| cpu_stop_n_i | input | 1 | Processor-lane stop, low halts selected lanes |
| pci_stop_n_i | input | 1 | Bus-lane stop, low halts selected lanes |
| sw_run_i | input | 1 | Software run bit, 0 halts bus-stop lanes |
| sel_a_i | input | NUM_LANES | Lane follows request line A |
| sel_b_i | input | NUM_LANES | Lane follows request line B |
| cpu_ctl_i | input | NUM_LANES | Lane follows the processor stop |
| pci_ctl_i | input | NUM_LANES | Lane follows the bus stop and software bit |
| park_hi_i | input | NUM_LANES | Park level of the true output |
| hiz_i | input | NUM_LANES | Release outputs while stopped |
| clk_t_o | output | NUM_LANES | Gated true clock |
| clk_c_o | output | NUM_LANES | Gated complement clock |
| oe_o | output | NUM_LANES | Output enable per lane |

## Verification
The sharp case is one lane seeing a release and a new stop in the same cycle. The lane is mapped both to the bus stop and to request B; the bus stop is held low until the lane parks, then on one edge the bus stop is released and request B is raised. Both pins pass through the same synchroniser and the same reference-edge filter, so the release and the new stop are accepted in the same cycle. The lane must not put out even one pulse, which the bench judges by counting zero toggles over a long window and by its every-cycle comparison with the reference model.

// File: rtl/cs_pkg.sv
// Shared constants for the clock stopper: the order of the control pins
// inside the synchroniser/filter vector.
package cs_pkg;
    localparam int IN_COUNT = 4;
    localparam int IN_REQ_A = 0;
    localparam int IN_REQ_B = 1;
    localparam int IN_CPU   = 2;
    localparam int IN_PCI   = 3;
endpackage

// File: rtl/cs_ref_edge.sv
// Detects falling edges of the reference clock (rising edges of its
// complement). Assumes ref_clk_i is synchronous to clk with each phase at
// least one clk cycle long. fall_o is high for one cycle per falling edge.
module cs_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk_i,
    output logic fall_o
);
    logic ref_q;
    logic ref_qq;

    // Two-stage history of the reference clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            ref_qq <= 1'b0;
        end else begin
            ref_q  <= ref_clk_i;
            ref_qq <= ref_q;
        end
    end

    assign fall_o = ref_qq & ~ref_q;
endmodule

// File: rtl/cs_sync_filter.sv
// Synchronises asynchronous control pins with two flops and accepts a new
// value only when two successive sample strobes see the same value.
// Assumes the pins are active low, so reset takes every pin as asserted (0).
module cs_sync_filter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic             sample_i,
    output logic [WIDTH-1:0] acc_o
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        logic meta_q;
        logic sync_q;
        logic last_q;
        logic acc_q;

        // Synchronise the pin, then qualify it on two agreeing strobes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
                acc_q  <= 1'b0;
            end else begin
                meta_q <= pin_i[k];
                sync_q <= meta_q;
                if (sample_i) begin
                    last_q <= sync_q;
                    if (sync_q == last_q) begin
                        acc_q <= sync_q;
                    end
                end
            end
        end

        assign acc_o[k] = acc_q;
    end
endmodule

// File: rtl/cs_lane_gate.sv
// Gates one lane clock. The run state changes only in a cycle where the
// registered lane clock equals the park level, so the true output never
// shows a runt or stretched pulse. Assumes lane_clk_i is synchronous to clk.
module cs_lane_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lane_clk_i,
    input  logic run_req_i,
    input  logic park_hi_i,
    input  logic hiz_i,
    output logic clk_t_o,
    output logic clk_c_o,
    output logic oe_o,
    output logic clk_q_o,
    output logic run_o
);
    logic clk_q;
    logic run_q;

    // Register the lane clock and move the run state at the park phase only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            run_q <= 1'b1;
        end else begin
            clk_q <= lane_clk_i;
            if (clk_q == park_hi_i) begin
                run_q <= run_req_i;
            end
        end
    end

    // Drive the pair: follow the clock while running, park while stopped.
    always_comb begin
        if (run_q) begin
            clk_t_o = clk_q;
            clk_c_o = ~clk_q;
        end else begin
            clk_t_o = park_hi_i;
            clk_c_o = 1'b0;
        end
        oe_o = run_q | ~hiz_i;
    end

    assign clk_q_o = clk_q;
    assign run_o   = run_q;
endmodule

// File: rtl/cs_clock_stopper.sv
// Top of the clock stopper. Qualifies four active-low control pins against
// the reference clock, combines them per lane with the selection bits, and
// gates each lane through cs_lane_gate. Assumes all clock inputs are
// synchronous to clk and slower than half its rate.
module cs_clock_stopper #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_clk_i,
    input  logic [NUM_LANES-1:0] lane_clk_i,
    input  logic                 req_a_n_i,
    input  logic                 req_b_n_i,
    input  logic                 cpu_stop_n_i,
    input  logic                 pci_stop_n_i,
    input  logic                 sw_run_i,
    input  logic [NUM_LANES-1:0] sel_a_i,
    input  logic [NUM_LANES-1:0] sel_b_i,
    input  logic [NUM_LANES-1:0] cpu_ctl_i,
    input  logic [NUM_LANES-1:0] pci_ctl_i,
    input  logic [NUM_LANES-1:0] park_hi_i,
    input  logic [NUM_LANES-1:0] hiz_i,
    output logic [NUM_LANES-1:0] clk_t_o,
    output logic [NUM_LANES-1:0] clk_c_o,
    output logic [NUM_LANES-1:0] oe_o
);
    import cs_pkg::*;

    logic                 ref_fall;
    logic [IN_COUNT-1:0]  pin_vec;
    logic [IN_COUNT-1:0]  acc_q;
    logic                 halt_a;
    logic                 halt_b;
    logic                 halt_cpu;
    logic                 halt_pci;
    logic [NUM_LANES-1:0] run_req;
    logic [NUM_LANES-1:0] lane_clk_q;
    logic [NUM_LANES-1:0] lane_run;

    cs_ref_edge i_ref_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk_i (ref_clk_i),
        .fall_o    (ref_fall)
    );

    // Pack the pins in the order the package fixes.
    always_comb begin
        pin_vec           = '0;
        pin_vec[IN_REQ_A] = req_a_n_i;
        pin_vec[IN_REQ_B] = req_b_n_i;
        pin_vec[IN_CPU]   = cpu_stop_n_i;
        pin_vec[IN_PCI]   = pci_stop_n_i;
    end

    cs_sync_filter #(.WIDTH(IN_COUNT)) i_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_vec),
        .sample_i (ref_fall),
        .acc_o    (acc_q)
    );

    // Turn accepted pin levels into halt conditions.
    always_comb begin
        halt_a   = acc_q[IN_REQ_A];
        halt_b   = acc_q[IN_REQ_B];
        halt_cpu = ~acc_q[IN_CPU];
        halt_pci = ~acc_q[IN_PCI] | ~sw_run_i;
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // A lane runs unless some condition it is mapped to is active.
        assign run_req[i] = ~((sel_a_i[i]   & halt_a)   |
                              (sel_b_i[i]   & halt_b)   |
                              (cpu_ctl_i[i] & halt_cpu) |
                              (pci_ctl_i[i] & halt_pci));

        cs_lane_gate i_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .lane_clk_i (lane_clk_i[i]),
            .run_req_i  (run_req[i]),
            .park_hi_i  (park_hi_i[i]),
            .hiz_i      (hiz_i[i]),
            .clk_t_o    (clk_t_o[i]),
            .clk_c_o    (clk_c_o[i]),
            .oe_o       (oe_o[i]),
            .clk_q_o    (lane_clk_q[i]),
            .run_o      (lane_run[i])
        );
    end
endmodule

// File: rtl/cs_clock_stopper_chk.sv
// Assertion checker for cs_clock_stopper, attached with bind below.
// Watches the accepted pin levels, the lane run states and the outputs.
module cs_clock_stopper_chk #(
    parameter int NUM_LANES = 4,
    parameter int IN_W      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_fall,
    input logic [IN_W-1:0]      acc_q,
    input logic [NUM_LANES-1:0] lane_clk_q,
    input logic [NUM_LANES-1:0] lane_run,
    input logic [NUM_LANES-1:0] park_hi_i,
    input logic [NUM_LANES-1:0] hiz_i,
    input logic [NUM_LANES-1:0] clk_t_o,
    input logic [NUM_LANES-1:0] clk_c_o,
    input logic [NUM_LANES-1:0] oe_o
);
    // R1
    accept_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> $past(ref_fall));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // R3
        stop_at_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lane_run[i]) |-> ($past(lane_clk_q[i]) == $past(park_hi_i[i])));

        // R3
        resume_at_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_run[i]) |-> ($past(lane_clk_q[i]) == $past(park_hi_i[i])));

        // R7
        no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(clk_t_o[i]) && $stable(park_hi_i[i])) |-> !$stable(lane_clk_q[i]));

        // R2
        parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_run[i] && !$past(lane_run[i]) && $stable(park_hi_i[i]))
                |-> ($stable(clk_t_o[i]) && !clk_c_o[i]));

        // R6
        driven_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hiz_i[i] || lane_run[i]) |-> oe_o[i]);
    end
endmodule

bind cs_clock_stopper cs_clock_stopper_chk #(
    .NUM_LANES (NUM_LANES),
    .IN_W      (cs_pkg::IN_COUNT)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_fall   (ref_fall),
    .acc_q      (acc_q),
    .lane_clk_q (lane_clk_q),
    .lane_run   (lane_run),
    .park_hi_i  (park_hi_i),
    .hiz_i      (hiz_i),
    .clk_t_o    (clk_t_o),
    .clk_c_o    (clk_c_o),
    .oe_o       (oe_o)
);

// File: tb/test_cs_clock_stopper.sv
`timescale 1ns/1ps
// Bench for cs_clock_stopper: a behavioural reference model advanced on
// every rising edge and compared with the outputs 2 ns later, plus directed
// checks on each requirement.
module test_cs_clock_stopper;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_clk = 1'b0;
    logic [N-1:0] lane_clk = '0;
    logic         req_a_n = 1'b0;
    logic         req_b_n = 1'b0;
    logic         cpu_stop_n = 1'b1;
    logic         pci_stop_n = 1'b1;
    logic         sw_run = 1'b1;
    logic [N-1:0] sel_a   = 4'b0001;
    logic [N-1:0] sel_b   = 4'b0010;
    logic [N-1:0] cpu_ctl = 4'b0100;
    logic [N-1:0] pci_ctl = 4'b1000;
    logic [N-1:0] park_hi = 4'b0100;
    logic [N-1:0] hiz     = 4'b0010;
    logic [N-1:0] clk_t;
    logic [N-1:0] clk_c;
    logic [N-1:0] oe;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    cs_clock_stopper #(.NUM_LANES(N)) i_cs_clock_stopper (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_clk_i    (ref_clk),
        .lane_clk_i   (lane_clk),
        .req_a_n_i    (req_a_n),
        .req_b_n_i    (req_b_n),
        .cpu_stop_n_i (cpu_stop_n),
        .pci_stop_n_i (pci_stop_n),
        .sw_run_i     (sw_run),
        .sel_a_i      (sel_a),
        .sel_b_i      (sel_b),
        .cpu_ctl_i    (cpu_ctl),
        .pci_ctl_i    (pci_ctl),
        .park_hi_i    (park_hi),
        .hiz_i        (hiz),
        .clk_t_o      (clk_t),
        .clk_c_o      (clk_c),
        .oe_o         (oe)
    );

    always #4 clk = ~clk;

    // Lane i has a half-period of i+2 cycles; reference half-period is 3.
    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < N; i++) lane_clk[i] <= ((cyc / (i + 2)) % 2) != 0;
        ref_clk <= ((cyc / 3) % 2) != 0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model state: pin order a, b, cpu, pci.
    logic [3:0]   m_s1, m_s2, m_prev, m_acc;
    logic         m_r1, m_r2;
    logic [N-1:0] m_clk, m_run;

    always @(posedge clk) begin
        logic fall, ha, hb, hc, hp, want;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_acc = '0;
            m_r1 = 1'b0; m_r2 = 1'b0; m_clk = '0; m_run = '1;
        end else begin
            fall = m_r2 && !m_r1;
            ha = m_acc[0]; hb = m_acc[1]; hc = !m_acc[2]; hp = !m_acc[3] || !sw_run;
            for (int i = 0; i < N; i++) begin
                want = !((sel_a[i] && ha) || (sel_b[i] && hb) ||
                         (cpu_ctl[i] && hc) || (pci_ctl[i] && hp));
                if (m_clk[i] == park_hi[i]) m_run[i] = want;
            end
            if (fall) begin
                for (int k = 0; k < 4; k++) if (m_s2[k] == m_prev[k]) m_acc[k] = m_s2[k];
                m_prev = m_s2;
            end
            m_s2 = m_s1;
            m_s1 = {pci_stop_n, cpu_stop_n, req_b_n, req_a_n};
            m_r2 = m_r1; m_r1 = ref_clk; m_clk = lane_clk;
        end
    end

    // Every-cycle comparison with the model, away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [N-1:0] et, ec, eo;
            for (int i = 0; i < N; i++) begin
                et[i] = m_run[i] ? m_clk[i] : park_hi[i];
                ec[i] = m_run[i] ? !m_clk[i] : 1'b0;
                eo[i] = m_run[i] || !hiz[i];
            end
            chk("R7 model true outputs", clk_t, et);
            chk("R2 model complement outputs", clk_c, ec);
            chk("R6 model output enables", oe, eo);
        end
    end

    task automatic count_tog(input int lane, input int cycles, output int n);
        logic prev;
        @(posedge clk); #2;
        prev = clk_t[lane];
        n = 0;
        repeat (cycles) begin
            @(posedge clk); #2;
            if (clk_t[lane] != prev) n++;
            prev = clk_t[lane];
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        wait_cyc(5);
        // R8: reset state
        chk("R8 reset true", clk_t, 0);
        chk("R8 reset complement", clk_c, 4'hF);
        chk("R8 reset oe", oe, 4'hF);
        rst_n = 1'b1;
        wait_cyc(40);

        // R1: no lane reacts within four cycles of a pin change
        req_a_n = 1'b1;
        count_tog(0, 4, n);
        chk("R1 lane0 toggles right after request rises", n, 2);
        wait_cyc(60);
        // R2: request A high parks lane 0 low on both outputs
        count_tog(0, 20, n);
        chk("R2 lane0 stopped toggles", n, 0);
        chk("R2 lane0 true parked", clk_t[0], 0);
        chk("R2 lane0 complement parked", clk_c[0], 0);
        chk("R6 lane0 driven while stopped", oe[0], 1);

        // R6: request B parks lane 1 with outputs released
        @(negedge clk); req_b_n = 1'b1;
        wait_cyc(60);
        chk("R6 lane1 released", oe[1], 0);
        chk("R2 lane1 true parked", clk_t[1], 0);
        // R9: lanes 2 and 3 ignore both request lines
        count_tog(2, 40, n);
        chk("R9 lane2 runs during request stops", n, 10);
        count_tog(3, 40, n);
        chk("R9 lane3 runs during request stops", n, 8);

        // R3: releasing request A restarts lane 0
        @(negedge clk); req_a_n = 1'b0; req_b_n = 1'b0;
        wait_cyc(60);
        count_tog(0, 40, n);
        chk("R3 lane0 resumed toggles", n, 20);
        chk("R3 lane1 driven again", oe[1], 1);

        // R1: a one-cycle pulse is rejected
        @(negedge clk); req_a_n = 1'b1;
        @(negedge clk); req_a_n = 1'b0;
        count_tog(0, 40, n);
        chk("R1 lane0 toggles after short pulse", n, 20);

        // R4: processor stop parks lane 2 high
        @(negedge clk); cpu_stop_n = 1'b0;
        wait_cyc(60);
        count_tog(2, 20, n);
        chk("R4 lane2 stopped toggles", n, 0);
        chk("R4 lane2 true parked high", clk_t[2], 1);
        chk("R4 lane2 complement parked low", clk_c[2], 0);
        @(negedge clk); hiz[2] = 1'b1;
        @(negedge clk);
        chk("R6 lane2 released while stopped", oe[2], 0);
        cpu_stop_n = 1'b1;
        wait_cyc(60);
        count_tog(2, 40, n);
        chk("R4 lane2 resumed toggles", n, 10);
        chk("R6 lane2 enabled while running", oe[2], 1);

        // R5: bus stop halts lane 3, lane 0 ignores it
        @(negedge clk); pci_stop_n = 1'b0;
        wait_cyc(60);
        count_tog(3, 30, n);
        chk("R5 lane3 stopped by bus stop", n, 0);
        chk("R5 lane3 parked low", clk_t[3], 0);
        count_tog(0, 40, n);
        chk("R5 lane0 ignores bus stop", n, 20);
        @(negedge clk); pci_stop_n = 1'b1;
        wait_cyc(60);
        count_tog(3, 40, n);
        chk("R5 lane3 resumed after bus stop", n, 8);

        // R5: software run bit
        @(negedge clk); sw_run = 1'b0;
        wait_cyc(40);
        count_tog(3, 30, n);
        chk("R5 lane3 stopped by software bit", n, 0);
        @(negedge clk); sw_run = 1'b1;
        wait_cyc(40);
        count_tog(3, 40, n);
        chk("R5 lane3 resumed by software bit", n, 8);

        // R3: release and new stop accepted together give no pulse
        @(negedge clk); sel_b[3] = 1'b1; pci_stop_n = 1'b0;
        wait_cyc(60);
        @(negedge clk); pci_stop_n = 1'b1; req_b_n = 1'b1;
        count_tog(3, 100, n);
        chk("R3 lane3 no pulse on handover", n, 0);
        @(negedge clk); req_b_n = 1'b0;
        wait_cyc(60);
        count_tog(3, 40, n);
        chk("R3 lane3 resumes after handover", n, 8);

        wait_cyc(4);
        finish_run();
    end
endmodule